// File: doc/BRIEF.md
# Thermal Trip Unit with Hysteretic Alarm Modes

The unit turns each finished signed temperature conversion into two alarm outputs. A hot-interrupt flag is judged against a hot limit and a lower release limit. An over-temperature (OS) alarm is judged against its own pair of limits. The hot interrupt runs in one of two modes. In repeat mode it re-raises after every acknowledged conversion while the temperature stays above the release limit. In single-shot mode it raises once and re-arms only after the temperature falls below the release limit. The OS alarm runs either as a pure hysteretic comparator or in the single-shot mode.

The reading is a two's-complement code with a parameterised number of fraction bits. Its integer part is compared, with signed arithmetic, against signed limits in whole-degree units. A shared output pin shows the OS alarm with selectable polarity, or a reset request, or idles high. All alarm state changes only on a conversion strobe or an acknowledge pulse, and it holds between them.

Top module: `thermal_trip_unit`

## Requirements
- R1: After reset, `hot_irq` and `os_alarm` are 0.
- R2: The reading `temp_code` is two's complement with FRAC_W fraction bits (default 9 bits, 0.5 degree LSB, so 0FAh is +125 and 1CEh is -25). Its integer part (floor, arithmetic shift) is compared as a signed number against signed 8-bit limits.
- R3: With `hot_once`=0, a strobe whose integer temperature is above `hot_lim` sets `hot_irq` on the following edge. The flag stays set until `stat_ack`.
- R4: With `hot_once`=0, once the temperature has exceeded `hot_lim`, every later strobe sets `hot_irq` again until a strobe sees a value below `hot_hyst`. That strobe clears `hot_irq` without an acknowledge.
- R5: With `hot_once`=1, `hot_irq` sets only on a strobe that exceeds `hot_lim` while the unit is not armed-over. It is cleared only by `stat_ack`. No further set happens until a strobe sees a value below `hot_hyst`.
- R6: With `os_once`=0, `os_alarm` becomes 1 on a strobe above `os_lim` and stays 1 until a strobe below `os_hyst`. `stat_ack` has no effect in this mode.
- R7: With `os_once`=1, `os_alarm` follows the single-shot rule of R5, using `os_lim` and `os_hyst`.
- R8: When the pin shows OS, `pin_level` equals `os_alarm` if `os_act_high`=1 and equals its inverse if `os_act_high`=0.
- R9: Pin selection by {`pin_os_en`,`pin_rst_en`}: 2'b10 shows OS, 2'b01 drives `pin_level` = ~`rst_req`, and 2'b00 or 2'b11 hold `pin_level` at 1.
- R10: Alarm flags change only on an edge where `conv_done` or `stat_ack` is high. When both are high, a set caused by the conversion wins over the acknowledge.
- R11: A value equal to a trip limit does not set an alarm, and a value equal to a release limit does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| temp_code | input | TEMP_W | Signed temperature reading with FRAC_W fraction bits |
| hot_lim | input | LIM_W | Signed hot trip limit, whole degrees |
| hot_hyst | input | LIM_W | Signed hot release limit, whole degrees |
| os_lim | input | LIM_W | Signed OS trip limit, whole degrees |
| os_hyst | input | LIM_W | Signed OS release limit, whole degrees |
| hot_once | input | 1 | Hot mode: 0 repeat, 1 single-shot |
| os_once | input | 1 | OS mode: 0 comparator, 1 single-shot |
| os_act_high | input | 1 | OS pin polarity: 1 active-high, 0 active-low |
| pin_os_en | input | 1 | Pin select bit for OS |
| pin_rst_en | input | 1 | Pin select bit for reset output |
| rst_req | input | 1 | Reset request shown on the pin in reset mode |
| stat_ack | input | 1 | Acknowledge pulse from a status read or clear |
| hot_irq | output | 1 | Hot-temperature interrupt flag |
| os_alarm | output | 1 | Over-temperature alarm flag |
| pin_level | output | 1 | Level of the shared pin |

## Verification
The in-line properties check on every cycle that flags hold between strobes and acknowledges, that an acknowledge without a strobe clears a single-shot or repeat flag, and that a comparator trip raises the alarm. They also check that a release strobe clears the repeat flag, that a single-shot flag never rises on a non-trip strobe, and that a disabled pin idles high. Some behaviour can only be shown by the bench's ordered scenarios: the re-fire after each acknowledge in repeat mode, the re-arm after a release in single-shot mode, floor rounding of fractional and negative readings, equality at both limits, and a set that coincides with an acknowledge.

// File: rtl/thermal_trip_pkg.sv
`timescale 1ns/1ps
package thermal_trip_pkg;
   typedef enum logic [1:0] {
      TRK_LEVEL  = 2'd0,
      TRK_REPEAT = 2'd1,
      TRK_ONCE   = 2'd2
   } trk_mode_e;

   typedef enum logic [1:0] {
      PIN_IDLE = 2'd0,
      PIN_OS   = 2'd1,
      PIN_RST  = 2'd2
   } pin_sel_e;
endpackage

// File: rtl/trip_limit_cmp.sv
`timescale 1ns/1ps
module trip_limit_cmp #(
   parameter int TEMP_W = 9,
   parameter int FRAC_W = 1,
   parameter int LIM_W  = 8,
   localparam int INT_W = TEMP_W - FRAC_W
) (
   input  logic [TEMP_W-1:0] reading,
   input  logic [LIM_W-1:0]  trip_lim,
   input  logic [LIM_W-1:0]  rel_lim,
   output logic              above,
   output logic              below
);
   logic [INT_W-1:0] whole;

   if (FRAC_W == 0) begin : g_nofrac
      assign whole = reading;
   end else begin : g_frac
      assign whole = reading[TEMP_W-1:FRAC_W];
   end

   if (LIM_W > INT_W) begin : g_bad_width
      $error("trip_limit_cmp: limit wider than integer part");
   end

   always_comb begin
      above = $signed(whole) > $signed(trip_lim);
      below = $signed(whole) < $signed(rel_lim);
   end
endmodule

// File: rtl/trip_tracker.sv
`timescale 1ns/1ps
module trip_tracker
   import thermal_trip_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  trk_mode_e mode,
   input  logic      strobe,
   input  logic      above,
   input  logic      below,
   input  logic      ack,
   output logic      flag
);
   logic over_q;
   logic over_d;
   logic flag_q;

   always_comb begin
      if (above)      over_d = 1'b1;
      else if (below) over_d = 1'b0;
      else            over_d = over_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         over_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (strobe) over_q <= over_d;
         unique case (mode)
            TRK_REPEAT: begin
               if (strobe && over_d)     flag_q <= 1'b1;
               else if (strobe && below) flag_q <= 1'b0;
               else if (ack)             flag_q <= 1'b0;
            end
            TRK_ONCE: begin
               if (strobe && above && !over_q) flag_q <= 1'b1;
               else if (ack)                   flag_q <= 1'b0;
            end
            default: begin
               if (strobe) flag_q <= over_d;
            end
         endcase
      end
   end

   assign flag = flag_q;

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !ack) |=> $stable(flag_q));
   p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != TRK_LEVEL && ack && !strobe) |=> !flag_q);
   p_level_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRK_LEVEL && strobe && above) |=> flag_q);
   p_auto_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRK_REPEAT && strobe && below && !above) |=> !flag_q);
   p_once_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRK_ONCE && strobe && !above) |=> !$rose(flag_q));
endmodule

// File: rtl/trip_pin_mux.sv
`timescale 1ns/1ps
module trip_pin_mux
   import thermal_trip_pkg::*;
(
   input  pin_sel_e sel,
   input  logic     os_flag,
   input  logic     act_high,
   input  logic     rst_req,
   output logic     level
);
   always_comb begin
      unique case (sel)
         PIN_OS:  level = act_high ? os_flag : ~os_flag;
         PIN_RST: level = ~rst_req;
         default: level = 1'b1;
      endcase
   end

   always_comb begin
      if (sel == PIN_IDLE) begin
         a_idle_high_r9: assert (level == 1'b1);
      end
   end
endmodule

// File: rtl/thermal_trip_unit.sv
`timescale 1ns/1ps
module thermal_trip_unit
   import thermal_trip_pkg::*;
#(
   parameter int TEMP_W = 9,
   parameter int FRAC_W = 1,
   parameter int LIM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [TEMP_W-1:0] temp_code,
   input  logic [LIM_W-1:0]  hot_lim,
   input  logic [LIM_W-1:0]  hot_hyst,
   input  logic [LIM_W-1:0]  os_lim,
   input  logic [LIM_W-1:0]  os_hyst,
   input  logic              hot_once,
   input  logic              os_once,
   input  logic              os_act_high,
   input  logic              pin_os_en,
   input  logic              pin_rst_en,
   input  logic              rst_req,
   input  logic              stat_ack,
   output logic              hot_irq,
   output logic              os_alarm,
   output logic              pin_level
);
   localparam int N_TRK = 2;
   localparam int INT_W = TEMP_W - FRAC_W;

   if (FRAC_W < 0 || FRAC_W >= TEMP_W) begin : g_bad_frac
      $error("thermal_trip_unit: FRAC_W out of range");
   end
   if (LIM_W > INT_W) begin : g_bad_lim
      $error("thermal_trip_unit: LIM_W exceeds integer width");
   end

   logic [LIM_W-1:0] trip_l [N_TRK];
   logic [LIM_W-1:0] rel_l  [N_TRK];
   trk_mode_e        mode_v [N_TRK];
   logic [N_TRK-1:0] above_v, below_v, flag_v;
   pin_sel_e         pin_sel;

   always_comb begin
      trip_l[0] = hot_lim;
      rel_l[0]  = hot_hyst;
      mode_v[0] = hot_once ? TRK_ONCE : TRK_REPEAT;
      trip_l[1] = os_lim;
      rel_l[1]  = os_hyst;
      mode_v[1] = os_once ? TRK_ONCE : TRK_LEVEL;
   end

   for (genvar k = 0; k < N_TRK; k++) begin : g_trk
      trip_limit_cmp #(.TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .LIM_W(LIM_W)) i_cmp (
         .reading (temp_code),
         .trip_lim(trip_l[k]),
         .rel_lim (rel_l[k]),
         .above   (above_v[k]),
         .below   (below_v[k])
      );
      trip_tracker i_trk (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (mode_v[k]),
         .strobe(conv_done),
         .above (above_v[k]),
         .below (below_v[k]),
         .ack   (stat_ack),
         .flag  (flag_v[k])
      );
   end

   always_comb begin
      unique case ({pin_os_en, pin_rst_en})
         2'b10:   pin_sel = PIN_OS;
         2'b01:   pin_sel = PIN_RST;
         default: pin_sel = PIN_IDLE;
      endcase
   end

   trip_pin_mux i_pin (
      .sel     (pin_sel),
      .os_flag (flag_v[1]),
      .act_high(os_act_high),
      .rst_req (rst_req),
      .level   (pin_level)
   );

   assign hot_irq  = flag_v[0];
   assign os_alarm = flag_v[1];

   p_comparator_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!os_once && stat_ack && !conv_done) |=> $stable(os_alarm));
   p_os_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_os_en && !pin_rst_en && !os_act_high) |-> (pin_level != os_alarm));
endmodule

// File: tb/test_thermal_trip_unit.sv
`timescale 1ns/1ps
module test_thermal_trip_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv_done = 1'b0;
   logic [8:0] temp_code = '0;
   logic [7:0] hot_lim = 8'd50, hot_hyst = 8'd45, os_lim = 8'd60, os_hyst = 8'd55;
   logic       hot_once = 1'b0, os_once = 1'b0, os_act_high = 1'b0;
   logic       pin_os_en = 1'b1, pin_rst_en = 1'b0, rst_req = 1'b0, stat_ack = 1'b0;
   logic       hot_irq, os_alarm, pin_level;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   string cur_req = "R1";

   int m_hov = 0, m_hirq = 0, m_oov = 0, m_oal = 0;

   always #4 clk = ~clk;

   thermal_trip_unit i_thermal_trip_unit (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .temp_code(temp_code),
      .hot_lim(hot_lim), .hot_hyst(hot_hyst), .os_lim(os_lim), .os_hyst(os_hyst),
      .hot_once(hot_once), .os_once(os_once), .os_act_high(os_act_high),
      .pin_os_en(pin_os_en), .pin_rst_en(pin_rst_en), .rst_req(rst_req),
      .stat_ack(stat_ack), .hot_irq(hot_irq), .os_alarm(os_alarm), .pin_level(pin_level)
   );

   // behavioural reference, evaluated on each rising edge
   always @(posedge clk) begin
      int t, hl, hh, ol, oh, hab, hbl, oab, obl, hnov, onov;
      t  = int'($signed(temp_code)) >>> 1;
      hl = int'($signed(hot_lim));  hh = int'($signed(hot_hyst));
      ol = int'($signed(os_lim));   oh = int'($signed(os_hyst));
      if (!rst_n) begin
         m_hov = 0; m_hirq = 0; m_oov = 0; m_oal = 0;
      end else begin
         hab = (conv_done && t > hl); hbl = (conv_done && t < hh);
         oab = (conv_done && t > ol); obl = (conv_done && t < oh);
         hnov = hab ? 1 : (hbl ? 0 : m_hov);
         onov = oab ? 1 : (obl ? 0 : m_oov);
         if (!hot_once) begin
            if (stat_ack) m_hirq = 0;
            if (conv_done && hnov) m_hirq = 1;
            else if (hbl) m_hirq = 0;
         end else begin
            if (stat_ack) m_hirq = 0;
            if (hab && !m_hov) m_hirq = 1;
         end
         if (!os_once) begin
            if (conv_done) m_oal = onov;
         end else begin
            if (stat_ack) m_oal = 0;
            if (oab && !m_oov) m_oal = 1;
         end
         if (conv_done) begin m_hov = hnov; m_oov = onov; end
      end
   end

   function automatic int model_pin();
      if (pin_os_en && !pin_rst_en) return os_act_high ? m_oal : 1 - m_oal;
      if (!pin_os_en && pin_rst_en) return rst_req ? 0 : 1;
      return 1;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the reference
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         chk(cur_req, "hot_irq vs model", int'(hot_irq), m_hirq);
         chk(cur_req, "os_alarm vs model", int'(os_alarm), m_oal);
         chk(cur_req, "pin_level vs model", int'(pin_level), model_pin());
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic conv(int raw9);
      @(negedge clk);
      conv_done = 1'b1; temp_code = 9'(raw9);
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); stat_ack = 1'b1;
      @(negedge clk); stat_ack = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      chk("R1", "hot_irq at reset", int'(hot_irq), 0);
      chk("R1", "os_alarm at reset", int'(os_alarm), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      chk("R1", "hot_irq after reset", int'(hot_irq), 0);

      // repeat mode
      cur_req = "R3";
      conv(80);   chk("R3", "below limit", int'(hot_irq), 0);
      conv(100);  chk("R11", "equal to hot limit", int'(hot_irq), 0);
      conv(102);  chk("R3", "above hot limit", int'(hot_irq), 1);
      idle(4);    chk("R10", "held between strobes", int'(hot_irq), 1);
      ack();      chk("R3", "acknowledged", int'(hot_irq), 0);
      cur_req = "R4";
      conv(96);   chk("R4", "re-fire between limits", int'(hot_irq), 1);
      ack();
      conv(90);   chk("R11", "equal to release limit re-fires", int'(hot_irq), 1);
      conv(88);   chk("R4", "self clear below release", int'(hot_irq), 0);
      conv(96);   chk("R4", "no fire when never over", int'(hot_irq), 0);

      // rounding and negative values
      cur_req = "R2";
      conv(9'h065); chk("R2", "50.5 floors to 50", int'(hot_irq), 0);
      conv(9'h0FA); chk("R2", "+125 trips", int'(hot_irq), 1);
      conv(9'h1CE); chk("R2", "-25 releases", int'(hot_irq), 0);
      hot_lim = 8'hF6; hot_hyst = 8'hEC;   // -10 and -20
      conv(-18);  chk("R2", "-9 above -10", int'(hot_irq), 1);
      conv(-41);  chk("R2", "-20.5 floors to -21, releases", int'(hot_irq), 0);
      hot_lim = 8'd50; hot_hyst = 8'd45;

      // single-shot hot
      cur_req = "R5";
      @(negedge clk); hot_once = 1'b1;
      conv(120);  chk("R5", "single-shot fires", int'(hot_irq), 1);
      conv(120);  chk("R5", "stays until ack", int'(hot_irq), 1);
      ack();      chk("R5", "ack clears", int'(hot_irq), 0);
      conv(110);  chk("R5", "no re-fire while over", int'(hot_irq), 0);
      conv(80);   chk("R5", "release re-arms, no fire", int'(hot_irq), 0);
      cur_req = "R10";
      @(negedge clk); conv_done = 1'b1; temp_code = 9'd104; stat_ack = 1'b1;
      @(negedge clk); conv_done = 1'b0; stat_ack = 1'b0;
      chk("R10", "set wins over ack", int'(hot_irq), 1);
      ack();
      @(negedge clk); hot_once = 1'b0;
      conv(60);

      // comparator OS
      cur_req = "R6";
      conv(122);  chk("R6", "os trips", int'(os_alarm), 1);
      chk("R8", "active-low pin", int'(pin_level), 0);
      conv(116);  chk("R6", "holds between limits", int'(os_alarm), 1);
      ack();      chk("R6", "ack ignored in comparator", int'(os_alarm), 1);
      @(negedge clk); os_act_high = 1'b1;
      #1 chk("R8", "active-high pin", int'(pin_level), 1);
      conv(110);  chk("R11", "equal to os release holds", int'(os_alarm), 1);
      conv(108);  chk("R6", "os releases", int'(os_alarm), 0);
      chk("R8", "active-high pin idle", int'(pin_level), 0);

      // single-shot OS
      cur_req = "R7";
      @(negedge clk); os_once = 1'b1;
      conv(130);  chk("R7", "os single-shot fires", int'(os_alarm), 1);
      ack();      chk("R7", "os ack clears", int'(os_alarm), 0);
      conv(130);  chk("R7", "os no re-fire", int'(os_alarm), 0);
      conv(100);  conv(130);
      chk("R7", "os re-armed fires", int'(os_alarm), 1);

      // pin selection
      cur_req = "R9";
      @(negedge clk); pin_os_en = 1'b0; pin_rst_en = 1'b1;
      #1 chk("R9", "reset mode idle", int'(pin_level), 1);
      @(negedge clk); rst_req = 1'b1;
      #1 chk("R9", "reset mode asserted", int'(pin_level), 0);
      @(negedge clk); pin_os_en = 1'b1;
      #1 chk("R9", "both set disables", int'(pin_level), 1);
      @(negedge clk); pin_os_en = 1'b0; pin_rst_en = 1'b0;
      #1 chk("R9", "neither set idles", int'(pin_level), 1);
      idle(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule